// File: doc/BRIEF.md
# Parallel Camera Sync-Mode Capture

This block receives pixel data from a parallel image sensor that frames its output with separate vertical sync, horizontal sync and field lines. A system clock oversamples the sensor's pixel clock. Each line, and the pixel clock's active edge, has its own polarity setting. On every active pixel clock edge the block samples the data bus. It picks the valid bits for the selected sample width and alignment, applies an optional internal lane shift, and decides whether the sample is stored.

Stored samples leave as a stream of zero-extended pixel words. A one-cycle valid strobe qualifies each word, and tags mark start of frame, end of line and the field the pixel belongs to. The field is captured when vertical sync becomes active. End of line is only known when horizontal or vertical sync drops, so the block holds each stored pixel until the next active pixel clock edge. The held pixel is released at that edge, tagged as end of line when the line has closed. Per-frame line and pixel counters are available as status.

Polarity settings apply at once. Format settings (width, alignment, shift, write-enable qualification) are copied into a shadow only while vertical sync is inactive, so a frame is never captured with mixed formats.

Top module: `cam_sync_capture`

## Requirements
- R1: `cfg_pclk_rise`, `cfg_vs_high`, `cfg_hs_high` and `cfg_fld_high` set the active edge of the pixel clock (1 = rising) and the active level (1 = high) of vertical sync, horizontal sync and field, each on its own.
- R2: `cfg_width` selects the sample width: 0 = 8 bits, 1 = 10 bits, 2 = 11 bits, 3 = 12 bits. For 8 and 10 bits, `cfg_upper` = 1 takes bus bits 11:4 or 11:2, and `cfg_upper` = 0 takes bits 7:0 or 9:0. 11 bits takes 10:0 and 12 bits takes 11:0. The result is zero-extended to 12 bits.
- R3: `cfg_shift` shifts the selected sample left by 0 (code 0), 2 (code 1) or 4 (code 2) lanes, with code 3 treated as 0. Bits shifted past bit 11 are dropped.
- R4: With `cfg_wen_qual` = 1, a sample is stored only when horizontal sync, vertical sync and `cam_wen` (active high) are all active at the pixel clock edge.
- R5: With `cfg_wen_qual` = 0, `cam_wen` has no effect, and a sample is stored whenever both syncs are active.
- R6: The field level is latched at the first pixel clock edge on which vertical sync is active. Every pixel of that frame carries it in `pix_field`, whatever the field input does later.
- R7: `pix_sof` is set on the first stored pixel of each frame and on no other pixel.
- R8: A stored pixel is output at the next pixel clock edge. `pix_eol` is set on it when that edge finds horizontal or vertical sync inactive with no new store.
- R9: Format settings change only while vertical sync is inactive. A change made during an active frame applies from the next frame.
- R10: `line_count` counts end-of-line pixels and `pixel_count` counts output pixels. Both clear at the pixel clock edge that starts a frame.
- R11: After reset, `pix_valid`, `pix_sof`, `pix_eol`, `line_count` and `pixel_count` are zero.
- R12: `pix_valid` is a single-cycle pulse and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sensor lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_vsync | input | 1 | Vertical sync |
| cam_hsync | input | 1 | Horizontal sync |
| cam_field | input | 1 | Interlace field indicator |
| cam_wen | input | 1 | External write enable, active high |
| cam_data | input | DW (12) | Sensor data bus |
| cfg_pclk_rise | input | 1 | 1: rising pixel clock edge active |
| cfg_vs_high | input | 1 | 1: vertical sync active high |
| cfg_hs_high | input | 1 | 1: horizontal sync active high |
| cfg_fld_high | input | 1 | 1: field input taken as is, 0: inverted |
| cfg_width | input | 2 | Sample width code |
| cfg_upper | input | 1 | Take upper bus bits in 8/10-bit modes |
| cfg_shift | input | 2 | Lane shift code |
| cfg_wen_qual | input | 1 | Qualify stores with cam_wen |
| pix_valid | output | 1 | Output pixel strobe |
| pix_data | output | DW (12) | Output pixel word |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of line |
| pix_field | output | 1 | Field of this pixel |
| line_count | output | CW (16) | Lines completed in current frame |
| pixel_count | output | CW (16) | Pixels output in current frame |

## Verification
The hardest case to reach is a format change while a frame is active. The bench changes width and alignment right after the first pixel of a line has been stored. It then checks that the rest of the frame keeps the old format and that the next frame uses the new one. Reversing the polarity settings is also delicate, because a raw level that was inactive can suddenly read as active and start a false frame or pixel edge. The bench changes the polarity settings and the raw line levels in the same time step to avoid this. End of line is checked for both causes, a falling horizontal sync and a falling vertical sync.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    typedef enum logic [1:0] {
        SW_8  = 2'd0,
        SW_10 = 2'd1,
        SW_11 = 2'd2,
        SW_12 = 2'd3
    } samp_width_e;

    typedef struct packed {
        samp_width_e width;
        logic        upper;
        logic [1:0]  shift;
        logic        wen_qual;
    } fmt_cfg_t;

endpackage

// File: rtl/cam_sig_norm.sv
module cam_sig_norm #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_pclk,
    input  logic          raw_vs,
    input  logic          raw_hs,
    input  logic          raw_fld,
    input  logic          raw_wen,
    input  logic [DW-1:0] raw_data,
    input  logic          pclk_rise,
    input  logic          vs_high,
    input  logic          hs_high,
    input  logic          fld_high,
    output logic          pix_edge,
    output logic          vs_act,
    output logic          hs_act,
    output logic          fld_act,
    output logic          wen_act,
    output logic [DW-1:0] data_smp
);

    typedef struct packed {
        logic          pclk;
        logic          pclk_prev;
        logic          vs;
        logic          hs;
        logic          fld;
        logic          wen;
        logic [DW-1:0] data;
    } norm_st_t;

    norm_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.pclk_prev = st_q.pclk;
        st_d.pclk      = pclk_rise ? raw_pclk : ~raw_pclk;
        st_d.vs        = vs_high   ? raw_vs   : ~raw_vs;
        st_d.hs        = hs_high   ? raw_hs   : ~raw_hs;
        st_d.fld       = fld_high  ? raw_fld  : ~raw_fld;
        st_d.wen       = raw_wen;
        st_d.data      = raw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_edge = st_q.pclk & ~st_q.pclk_prev;
    assign vs_act   = st_q.vs;
    assign hs_act   = st_q.hs;
    assign fld_act  = st_q.fld;
    assign wen_act  = st_q.wen;
    assign data_smp = st_q.data;

    AST_EDGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_edge |=> !pix_edge); // R12

endmodule

// File: rtl/cam_bit_select.sv
module cam_bit_select
    import cam_cap_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw,
    input  samp_width_e   width,
    input  logic          upper,
    input  logic [1:0]    shift,
    output logic [DW-1:0] sel
);

    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    int            nbits;
    int            lanes;
    logic [DW-1:0] mask;
    logic [DW-1:0] val;

    always_comb begin
        case (width)
            SW_8:    nbits = 8;
            SW_10:   nbits = 10;
            SW_11:   nbits = 11;
            default: nbits = 12;
        endcase
        case (shift)
            2'd1:    lanes = 2;
            2'd2:    lanes = 4;
            default: lanes = 0;
        endcase
        mask = ALL_ONES >> (DW - nbits);
        if (upper && (width == SW_8 || width == SW_10))
            val = raw >> (DW - nbits);
        else
            val = raw & mask;
        sel = val << lanes;
    end

endmodule

// File: rtl/cam_frame_track.sv
module cam_frame_track
    import cam_cap_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_edge,
    input  logic          vs_act,
    input  logic          hs_act,
    input  logic          fld_act,
    input  logic          wen_act,
    input  logic [DW-1:0] sel_data,
    input  fmt_cfg_t      cfg_in,
    output fmt_cfg_t      fmt_cur,
    output logic          pix_valid,
    output logic [DW-1:0] pix_data,
    output logic          pix_sof,
    output logic          pix_eol,
    output logic          pix_field,
    output logic [CW-1:0] line_count,
    output logic [CW-1:0] pixel_count
);

    typedef struct packed {
        fmt_cfg_t      fmt;
        logic          vs_prev;
        logic          field;
        logic          sof_pend;
        logic          hold_v;
        logic [DW-1:0] hold_d;
        logic          hold_sof;
        logic          hold_fld;
        logic          o_v;
        logic [DW-1:0] o_d;
        logic          o_sof;
        logic          o_eol;
        logic          o_fld;
        logic [CW-1:0] lines;
        logic [CW-1:0] pixels;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    store, fstart, fld_now;

    always_comb begin
        st_d       = st_q;
        st_d.o_v   = 1'b0;
        st_d.o_sof = 1'b0;
        st_d.o_eol = 1'b0;
        store      = vs_act && hs_act && (!st_q.fmt.wen_qual || wen_act);
        fstart     = vs_act && !st_q.vs_prev;
        fld_now    = fstart ? fld_act : st_q.field;

        if (!vs_act) st_d.fmt = cfg_in;

        if (pix_edge) begin
            st_d.vs_prev = vs_act;
            if (fstart) begin
                st_d.field    = fld_act;
                st_d.sof_pend = 1'b1;
                st_d.lines    = '0;
                st_d.pixels   = '0;
            end
            if (store) begin
                if (st_q.hold_v) begin
                    st_d.o_v    = 1'b1;
                    st_d.o_d    = st_q.hold_d;
                    st_d.o_sof  = st_q.hold_sof;
                    st_d.o_fld  = st_q.hold_fld;
                    st_d.pixels = st_d.pixels + 1'b1;
                end
                st_d.hold_v   = 1'b1;
                st_d.hold_d   = sel_data;
                st_d.hold_sof = st_q.sof_pend || fstart;
                st_d.hold_fld = fld_now;
                st_d.sof_pend = 1'b0;
            end else if (st_q.hold_v && (!hs_act || !vs_act)) begin
                st_d.o_v    = 1'b1;
                st_d.o_d    = st_q.hold_d;
                st_d.o_sof  = st_q.hold_sof;
                st_d.o_fld  = st_q.hold_fld;
                st_d.o_eol  = 1'b1;
                st_d.hold_v = 1'b0;
                st_d.pixels = st_d.pixels + 1'b1;
                st_d.lines  = st_d.lines + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fmt_cur     = st_q.fmt;
    assign pix_valid   = st_q.o_v;
    assign pix_data    = st_q.o_d;
    assign pix_sof     = st_q.o_sof;
    assign pix_eol     = st_q.o_eol;
    assign pix_field   = st_q.o_fld;
    assign line_count  = st_q.lines;
    assign pixel_count = st_q.pixels;

    AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> pix_valid); // R7
    AST_EOL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |-> pix_valid); // R8
    AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vs_act) |-> $stable(st_q.fmt)); // R9
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_edge && vs_act && !st_q.vs_prev) |=> (line_count == '0 && pixel_count <= 1)); // R10
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid); // R12

endmodule

// File: rtl/cam_sync_capture.sv
module cam_sync_capture
    import cam_cap_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cam_pclk,
    input  logic          cam_vsync,
    input  logic          cam_hsync,
    input  logic          cam_field,
    input  logic          cam_wen,
    input  logic [DW-1:0] cam_data,
    input  logic          cfg_pclk_rise,
    input  logic          cfg_vs_high,
    input  logic          cfg_hs_high,
    input  logic          cfg_fld_high,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_upper,
    input  logic [1:0]    cfg_shift,
    input  logic          cfg_wen_qual,
    output logic          pix_valid,
    output logic [DW-1:0] pix_data,
    output logic          pix_sof,
    output logic          pix_eol,
    output logic          pix_field,
    output logic [CW-1:0] line_count,
    output logic [CW-1:0] pixel_count
);

    logic          edge_s, vs_s, hs_s, fld_s, wen_s;
    logic [DW-1:0] data_s, sel_s;
    fmt_cfg_t      cfg_in, fmt_cur;

    assign cfg_in = '{width: samp_width_e'(cfg_width), upper: cfg_upper,
                      shift: cfg_shift, wen_qual: cfg_wen_qual};

    cam_sig_norm #(.DW(DW)) u_norm (
        .clk(clk), .rst_n(rst_n),
        .raw_pclk(cam_pclk), .raw_vs(cam_vsync), .raw_hs(cam_hsync),
        .raw_fld(cam_field), .raw_wen(cam_wen), .raw_data(cam_data),
        .pclk_rise(cfg_pclk_rise), .vs_high(cfg_vs_high),
        .hs_high(cfg_hs_high), .fld_high(cfg_fld_high),
        .pix_edge(edge_s), .vs_act(vs_s), .hs_act(hs_s),
        .fld_act(fld_s), .wen_act(wen_s), .data_smp(data_s)
    );

    cam_bit_select #(.DW(DW)) u_sel (
        .raw(data_s), .width(fmt_cur.width), .upper(fmt_cur.upper),
        .shift(fmt_cur.shift), .sel(sel_s)
    );

    cam_frame_track #(.DW(DW), .CW(CW)) u_trk (
        .clk(clk), .rst_n(rst_n), .pix_edge(edge_s), .vs_act(vs_s),
        .hs_act(hs_s), .fld_act(fld_s), .wen_act(wen_s), .sel_data(sel_s),
        .cfg_in(cfg_in), .fmt_cur(fmt_cur),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_field(pix_field),
        .line_count(line_count), .pixel_count(pixel_count)
    );

endmodule

// File: tb/cam_sync_capture_test.sv
module cam_sync_capture_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cam_pclk, cam_vsync, cam_hsync, cam_field, cam_wen;
    logic [11:0] cam_data;
    logic        cfg_pclk_rise, cfg_vs_high, cfg_hs_high, cfg_fld_high;
    logic [1:0]  cfg_width, cfg_shift;
    logic        cfg_upper, cfg_wen_qual;
    logic        pix_valid, pix_sof, pix_eol, pix_field;
    logic [11:0] pix_data;
    logic [15:0] line_count, pixel_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [11:0] cap_d   [64];
    logic        cap_sof [64];
    logic        cap_eol [64];
    logic        cap_fld [64];
    int          cap_n   = 0;
    int          doubles = 0;
    logic        prev_v  = 1'b0;

    always #5 clk = ~clk;

    cam_sync_capture uut (.*);

    // vector: [28:27] width, [26] upper, [25:24] shift, [23:12] bus, [11:0] expected
    localparam int NV = 14;
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 1'b0, 2'd0, 12'hABC, 12'h0BC},
        {2'd0, 1'b1, 2'd0, 12'hABC, 12'h0AB},
        {2'd1, 1'b0, 2'd0, 12'hABC, 12'h2BC},
        {2'd1, 1'b1, 2'd0, 12'hABC, 12'h2AF},
        {2'd2, 1'b0, 2'd0, 12'hABC, 12'h2BC},
        {2'd2, 1'b1, 2'd0, 12'hABC, 12'h2BC},
        {2'd3, 1'b0, 2'd0, 12'hABC, 12'hABC},
        {2'd0, 1'b0, 2'd1, 12'hABC, 12'h2F0},
        {2'd0, 1'b0, 2'd2, 12'hABC, 12'hBC0},
        {2'd3, 1'b0, 2'd2, 12'hABC, 12'hBC0},
        {2'd1, 1'b1, 2'd1, 12'hABC, 12'hABC},
        {2'd2, 1'b0, 2'd1, 12'hABC, 12'hAF0},
        {2'd3, 1'b0, 2'd3, 12'hABC, 12'hABC},
        {2'd3, 1'b0, 2'd1, 12'h5A3, 12'h68C}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_valid) begin
                if (cap_n < 64) begin
                    cap_d[cap_n]   = pix_data;
                    cap_sof[cap_n] = pix_sof;
                    cap_eol[cap_n] = pix_eol;
                    cap_fld[cap_n] = pix_field;
                end
                cap_n++;
                if (prev_v) doubles++;
            end
            prev_v = pix_valid;
        end
    end

    function automatic logic lvl(input logic act, input logic pol);
        return pol ? act : ~act;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic vs, input logic hs, input logic wen,
                         input logic fld, input logic [11:0] d);
        @(negedge clk);
        cam_vsync = lvl(vs, cfg_vs_high);
        cam_hsync = lvl(hs, cfg_hs_high);
        cam_field = lvl(fld, cfg_fld_high);
        cam_wen   = wen;
        cam_data  = d;
        cam_pclk  = lvl(1'b0, cfg_pclk_rise);
        repeat (3) @(negedge clk);
        cam_pclk  = lvl(1'b1, cfg_pclk_rise);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
    endtask

    task automatic set_pol(input logic pr, input logic vh, input logic hh, input logic fh);
        @(negedge clk);
        cfg_pclk_rise = pr; cfg_vs_high = vh; cfg_hs_high = hh; cfg_fld_high = fh;
        cam_pclk  = lvl(1'b0, pr);
        cam_vsync = lvl(1'b0, vh);
        cam_hsync = lvl(1'b0, hh);
        cam_field = lvl(1'b0, fh);
    endtask

    task automatic set_fmt(input logic [1:0] w, input logic up, input logic [1:0] sh, input logic wq);
        cfg_width = w; cfg_upper = up; cfg_shift = sh; cfg_wen_qual = wq;
        idle();
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_pclk_rise = 1'b1; cfg_vs_high = 1'b1; cfg_hs_high = 1'b1; cfg_fld_high = 1'b1;
        cfg_width = 2'd3; cfg_upper = 1'b0; cfg_shift = 2'd0; cfg_wen_qual = 1'b0;
        cam_pclk = 1'b0; cam_vsync = 1'b0; cam_hsync = 1'b0; cam_field = 1'b0;
        cam_wen = 1'b0; cam_data = '0;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(pix_valid == 1'b0 && pix_sof == 1'b0 && pix_eol == 1'b0, "R11 flags", pix_valid, 0);
        chk(line_count == 0 && pixel_count == 0, "R11 counters", pixel_count, 0);
        rst_n = 1'b1;
        idle();

        // table: R2 width/alignment, R3 shift
        for (int i = 0; i < NV; i++) begin
            set_fmt(VEC[i][28:27], VEC[i][26], VEC[i][25:24], 1'b0);
            cap_n = 0;
            drive(1'b1, 1'b1, 1'b0, 1'b0, VEC[i][23:12]);
            drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
            idle();
            chk(cap_n == 1, "R2 pixel count", cap_n, 1);
            chk(cap_d[0] == VEC[i][11:0], "R2/R3 data", cap_d[0], VEC[i][11:0]);
            chk(cap_sof[0] && cap_eol[0], "R7/R8 single pixel tags", {cap_sof[0], cap_eol[0]}, 3);
        end

        // R7 R8 R10 two lines
        set_fmt(2'd3, 1'b0, 2'd0, 1'b0);
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h111);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h222);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h333);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h444);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h555);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        chk(cap_n == 5, "R8 pixels out", cap_n, 5);
        chk(cap_d[3] == 12'h444, "R8 order", cap_d[3], 12'h444);
        chk(cap_sof[0] && !cap_sof[1] && !cap_sof[3], "R7 sof first only", {cap_sof[0], cap_sof[1], cap_sof[3]}, 4);
        chk(!cap_eol[0] && !cap_eol[1] && cap_eol[2] && !cap_eol[3] && cap_eol[4], "R8 eol positions",
            {cap_eol[0], cap_eol[1], cap_eol[2], cap_eol[3], cap_eol[4]}, 5);
        chk(line_count == 2, "R10 lines", line_count, 2);
        chk(pixel_count == 5, "R10 pixels", pixel_count, 5);
        idle();
        chk(line_count == 2 && pixel_count == 5, "R10 hold after frame", pixel_count, 5);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        chk(line_count == 0 && pixel_count == 0, "R10 clear at frame start", pixel_count, 0);
        idle();

        // R8 eol when vertical sync drops with horizontal sync still active
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h0A1);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h0A2);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h0A3);
        chk(cap_n == 2 && cap_eol[1] && cap_d[1] == 12'h0A2, "R8 eol on vsync drop", cap_d[1], 12'h0A2);
        idle();

        // R4 write-enable qualification
        set_fmt(2'd3, 1'b0, 2'd0, 1'b1);
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b1, 1'b0, 12'h101);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h102);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 12'h103);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 12'h104);
        idle();
        chk(cap_n == 2, "R4 stored count", cap_n, 2);
        chk(cap_d[0] == 12'h101 && cap_d[1] == 12'h103, "R4 stored data", cap_d[1], 12'h103);
        chk(cap_eol[1], "R4 eol on last qualified", cap_eol[1], 1);

        // R5 write enable ignored
        set_fmt(2'd3, 1'b0, 2'd0, 1'b0);
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b1, 1'b0, 12'h201);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h202);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h203);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        idle();
        chk(cap_n == 3 && cap_d[1] == 12'h202, "R5 wen ignored", cap_n, 3);

        // R6 field latch
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h301);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h302);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        idle();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h303);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h304);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
        idle();
        chk(cap_n == 4, "R6 count", cap_n, 4);
        chk(cap_fld[0] && cap_fld[1], "R6 field one held", {cap_fld[0], cap_fld[1]}, 3);
        chk(!cap_fld[2] && !cap_fld[3], "R6 field zero held", {cap_fld[2], cap_fld[3]}, 0);

        // R9 format change mid-frame
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'hABC);
        cfg_width = 2'd0; cfg_upper = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'hABC);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        idle();
        idle();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'hABC);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        idle();
        chk(cap_n == 3, "R9 count", cap_n, 3);
        chk(cap_d[1] == 12'hABC, "R9 frozen mid-frame", cap_d[1], 12'hABC);
        chk(cap_d[2] == 12'h0AB, "R9 applied next frame", cap_d[2], 12'h0AB);

        // R1 inverted polarities
        set_fmt(2'd3, 1'b0, 2'd0, 1'b0);
        set_pol(1'b0, 1'b0, 1'b0, 1'b0);
        idle();
        cap_n = 0;
        drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h123);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 12'h456);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
        idle();
        chk(cap_n == 2, "R1 count", cap_n, 2);
        chk(cap_d[0] == 12'h123 && cap_d[1] == 12'h456, "R1 data", cap_d[1], 12'h456);
        chk(cap_sof[0] && cap_eol[1] && cap_fld[0], "R1 tags", {cap_sof[0], cap_eol[1], cap_fld[0]}, 7);
        set_pol(1'b1, 1'b1, 1'b1, 1'b1);
        idle();

        // R12 single-cycle strobe
        chk(doubles == 0, "R12 valid pulse", doubles, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule